// File: doc/BRIEF.md
# Serial Fault Readout Port

This block is the target side of a four-wire serial port through which a host reads a latched fault register. The fault register sits outside the block and covers four low-side switch channels, each with a 2-bit fault code. The host pulls the active-low select line down. From that moment the data output carries a single flag that is high when any channel holds a non-zero code. On the first rising serial clock of the frame, the block copies all codes into its transmit shift register. In the same step it sends a one-cycle clear pulse to the fault register, so faults that arise during the read are kept for the next frame. The data output changes on rising clock edges, and the host's input bits are taken on falling edges. All serial pins are sampled by a faster system clock through two-flop synchronizers, and their edges are found in that clock domain.

A state machine drives the frame. It has three states. **IDLE**: select is high and the output is off. **ARMED**: select is low, no clock edge has come yet, and the live any-fault flag is shown. **SHIFT**: the snapshot is taken and bits are shifted out. There are four transitions. *open* (IDLE→ARMED) happens on the select falling edge. *capture* (ARMED→SHIFT) happens on the first clock rise and does the snapshot and the clear. *abort* (ARMED→IDLE) happens when select rises with no clock edge. *close* (SHIFT→IDLE) happens when select rises and stores the received word.

Top module: `diag_spi_readout`

## Requirements
- R1: While select is low and the first clock rise has not been seen, the data bit equals the OR of all eight fault-code bits, and it follows them live.
- R2: The output enable goes high within 3 system cycles after select falls.
- R3: The output enable is low in reset and while select is high. In that condition the data output is high impedance.
- R4: The frame is 9 bits: the any-fault flag, then channel 0 to channel 3, each code MSB first. Channel n sits at fault-code bits [2n+1:2n]. The first rising edge shows the flag, and each later rising edge moves to the next bit. Bits after the ninth read 0.
- R5: The first clock rise of a frame takes the snapshot and gives exactly one clear pulse that lasts one system cycle. No other clear pulse comes in that frame.
- R6: Faults that reach the fault register after the snapshot do not appear in the current frame. They are reported in the next frame.
- R7: Input data is sampled on falling clock edges. When select rises, the received word holds the last 9 sampled bits, with the earliest of them at bit 8.
- R8: If select rises before any clock edge, there is no snapshot and no clear pulse, and the received word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock, low when select changes |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when not selected |
| spi_miso_oe | output | 1 | Enable for the data output |
| fault_code_i | input | 8 | Latched fault codes, 2 bits per channel |
| fault_clr_o | output | 1 | One-cycle clear to the fault register |
| rx_word_o | output | 9 | Last received input word |

## Verification
A state machine stuck in ARMED would keep showing the live flag instead of the frame, so the second bit sampled by the host would already be wrong. If the state returned to IDLE early, the output enable would drop within three system cycles. A clear that is missing or doubled shows at once as a fault register that is not emptied or is emptied twice. A snapshot taken at the wrong time shows up in the next frame as a fault that is lost or reported twice. A shift register that is off by one position corrupts the channel order from the second bit onward.

// File: rtl/diag_spi_pkg.sv
package diag_spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_t;
endpackage

// File: rtl/diag_pin_sync.sv
module diag_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/diag_tx_shift.sv
module diag_tx_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] load_val_i,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= load_val_i;
        else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/diag_spi_readout.sv
module diag_spi_readout
    import diag_spi_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sck,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic                       spi_miso_oe,
    input  logic [NUM_CH*CODE_W-1:0]   fault_code_i,
    output logic                       fault_clr_o,
    output logic [NUM_CH*CODE_W:0]     rx_word_o
);
    localparam int CODES_W = NUM_CH * CODE_W;
    localparam int FRAME_W = CODES_W + 1;
    // pin order in the synchronized vector: {mosi, sck, cs_n}
    localparam logic [2:0] PIN_RST = 3'b001;

    logic [2:0] pins_s;
    logic       cs_lvl, sck_lvl, mosi_lvl;
    logic       cs_prev_q, sck_prev_q;
    logic       cs_fall, cs_rise, sck_rise, sck_fall;

    diag_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) pin_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({spi_mosi, spi_sck, spi_cs_n}),
        .q_o  (pins_s)
    );

    assign cs_lvl   = pins_s[0];
    assign sck_lvl  = pins_s[1];
    assign mosi_lvl = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_prev_q  <= cs_lvl;
            sck_prev_q <= sck_lvl;
        end
    end

    assign cs_fall  =  cs_prev_q  & ~cs_lvl;
    assign cs_rise  = ~cs_prev_q  &  cs_lvl;
    assign sck_rise = ~sck_prev_q &  sck_lvl;
    assign sck_fall =  sck_prev_q & ~sck_lvl;

    // snapshot image: any-fault flag, then channel 0 upward, MSB first
    logic               any_fault;
    logic [FRAME_W-1:0] snap;

    assign any_fault      = |fault_code_i;
    assign snap[FRAME_W-1] = any_fault;
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_snap
        assign snap[FRAME_W-2-ch*CODE_W -: CODE_W] = fault_code_i[ch*CODE_W +: CODE_W];
    end

    // state machine
    rd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic load, shift, rx_cap, rx_commit;

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        shift     = 1'b0;
        rx_cap    = 1'b0;
        rx_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_ARMED;            // open
            end
            ST_ARMED: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;                      // abort
                end else if (sck_rise) begin
                    state_d = ST_SHIFT;                     // capture
                    load    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cs_rise) begin
                    state_d   = ST_IDLE;                    // close
                    rx_commit = 1'b1;
                end else begin
                    shift  = sck_rise;
                    rx_cap = sck_fall;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    diag_tx_shift #(.W(FRAME_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .shift_i   (shift),
        .load_val_i(snap),
        .msb_o     (tx_msb)
    );

    logic               tx_msb;
    logic [FRAME_W-1:0] rx_sr_q;
    logic               miso_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr_q     <= '0;
            rx_word_o   <= '0;
            fault_clr_o <= 1'b0;
        end else begin
            fault_clr_o <= load;
            if (load)        rx_sr_q <= '0;
            else if (rx_cap) rx_sr_q <= {rx_sr_q[FRAME_W-2:0], mosi_lvl};
            if (rx_commit)   rx_word_o <= rx_sr_q;
        end
    end

    assign spi_miso_oe = (state_q != ST_IDLE);
    assign miso_bit    = (state_q == ST_ARMED) ? any_fault : tx_msb;
    assign spi_miso    = spi_miso_oe ? miso_bit : 1'bz;
endmodule

// File: rtl/diag_spi_readout_chk.sv
module diag_spi_readout_chk
    import diag_spi_pkg::*;
#(
    parameter int CODES_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input rd_state_t          state_q,
    input logic               cs_lvl,
    input logic               fault_clr_o,
    input logic               spi_miso_oe,
    input logic               miso_bit,
    input logic               tx_msb,
    input logic [CODES_W-1:0] fault_code_i
);
    p_lead_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (miso_bit == (|fault_code_i)));

    p_off_when_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_lvl) && cs_lvl) |-> !spi_miso_oe);

    p_snap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_o |-> (tx_msb == (|$past(fault_code_i))));

    p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_o |=> !fault_clr_o);

    p_clr_on_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_o |-> ($past(state_q) == ST_ARMED && state_q == ST_SHIFT));

    p_abort_no_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ARMED && state_q == ST_IDLE) |-> !fault_clr_o);
endmodule

bind diag_spi_readout diag_spi_readout_chk #(.CODES_W(CODES_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .cs_lvl      (cs_lvl),
    .fault_clr_o (fault_clr_o),
    .spi_miso_oe (spi_miso_oe),
    .miso_bit    (miso_bit),
    .tx_msb      (tx_msb),
    .fault_code_i(fault_code_i)
);

// File: tb/diag_spi_readout_tb.sv
module diag_spi_readout_tb_top;
    localparam int HP = 10;   // serial half period in system cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic [7:0] flt_q;
    logic       fault_clr_o;
    logic [8:0] rx_word_o;

    logic       inj_en = 1'b0;
    logic [7:0] inj_val = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int clr_cnt  = 0;
    int bit_idx  = 0;
    logic exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    diag_spi_readout dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .fault_code_i(flt_q),
        .fault_clr_o (fault_clr_o),
        .rx_word_o   (rx_word_o)
    );

    // external fault register model
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           flt_q <= '0;
        else if (fault_clr_o) flt_q <= inj_en ? inj_val : 8'h00;
        else if (inj_en)      flt_q <= flt_q | inj_val;
    end

    always @(posedge clk) if (rst_n && fault_clr_o) clr_cnt++;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares each bit the host would sample on a falling edge
    always @(negedge spi_sck) begin
        if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected bit", int'(spi_miso), -1);
        end else begin
            logic e;
            e = exp_q.pop_front();
            chk(spi_miso === e && spi_miso_oe, $sformatf("R4 bit %0d", bit_idx),
                int'(spi_miso), int'(e));
        end
        bit_idx++;
    end

    function automatic logic [8:0] frame_of(input logic [7:0] c);
        logic [8:0] f;
        f[8] = |c;
        for (int ch = 0; ch < 4; ch++) begin
            f[7-2*ch] = c[2*ch+1];
            f[6-2*ch] = c[2*ch];
        end
        return f;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic inject(input logic [7:0] v);
        @(negedge clk);
        inj_en  = 1'b1;
        inj_val = v;
        @(negedge clk);
        inj_en  = 1'b0;
        inj_val = '0;
    endtask

    // driver: pushes expected bits, then runs a frame
    task automatic run_frame(input logic [8:0] mosi_w, input int nbits,
                             input int inj_at, input logic [7:0] inj_v);
        logic [8:0] f;
        logic [8:0] rx_exp;
        logic       b;
        int         clr0;
        f      = frame_of(flt_q);
        rx_exp = '0;
        clr0   = clr_cnt;
        bit_idx = 0;
        for (int i = 0; i < nbits; i++) exp_q.push_back(i < 9 ? f[8-i] : 1'b0);
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HP);
        chk(spi_miso_oe === 1'b1, "R2 enable after select", int'(spi_miso_oe), 1);
        chk(spi_miso === f[8], "R1 lead flag", int'(spi_miso), int'(f[8]));
        for (int i = 0; i < nbits; i++) begin
            b = (i < 9) ? mosi_w[8-i] : 1'b0;
            @(negedge clk);
            spi_sck  = 1'b1;
            spi_mosi = b;   // changes with the rise: only fall sampling sees it
            rx_exp   = {rx_exp[7:0], b};
            wait_clk(HP);
            if (i == inj_at) inject(inj_v);
            @(negedge clk);
            spi_sck = 1'b0;
            wait_clk(HP);
        end
        @(negedge clk);
        spi_cs_n = 1'b1;
        wait_clk(HP);
        chk(spi_miso_oe === 1'b0, "R3 disabled after frame", int'(spi_miso_oe), 0);
        chk(clr_cnt - clr0 == 1, "R5 one clear per frame", clr_cnt - clr0, 1);
        chk(rx_word_o == rx_exp, "R7 received word", int'(rx_word_o), int'(rx_exp));
        chk(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int clr0;
        wait_clk(5);
        chk(spi_miso_oe === 1'b0, "R3 reset enable", int'(spi_miso_oe), 0);
        chk(fault_clr_o === 1'b0, "R5 reset clear", int'(fault_clr_o), 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk(spi_miso_oe === 1'b0, "R3 idle enable", int'(spi_miso_oe), 0);

        // R4/R5/R7: mixed channel codes
        inject(8'h12);
        run_frame(9'h1A5, 9, -1, 8'h00);
        chk(flt_q == 8'h00, "R5 fault register cleared", int'(flt_q), 0);

        // R1: no faults, lead flag low
        run_frame(9'h05A, 9, -1, 8'h00);

        // R1 live flag and R8 aborted frame
        clr0 = clr_cnt;
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(HP);
        chk(spi_miso === 1'b0, "R1 live flag low", int'(spi_miso), 0);
        inject(8'h80);
        wait_clk(4);
        chk(spi_miso === 1'b1, "R1 live flag follows", int'(spi_miso), 1);
        @(negedge clk);
        spi_cs_n = 1'b1;
        wait_clk(HP);
        chk(clr_cnt == clr0, "R8 no clear on abort", clr_cnt, clr0);
        chk(flt_q == 8'h80, "R8 faults kept", int'(flt_q), 8'h80);
        chk(rx_word_o == 9'h05A, "R8 received word kept", int'(rx_word_o), 9'h05A);
        chk(spi_miso_oe === 1'b0, "R3 off after abort", int'(spi_miso_oe), 0);
        run_frame(9'h155, 9, -1, 8'h00);

        // R6: fault arriving mid-read goes to the next frame
        inject(8'h03);
        run_frame(9'h0F0, 9, 3, 8'h0C);
        chk(flt_q == 8'h0C, "R6 late fault retained", int'(flt_q), 8'h0C);
        run_frame(9'h1FF, 9, -1, 8'h00);

        // R4: bits past the ninth read 0; R7 keeps last nine inputs
        inject(8'hFF);
        run_frame(9'h1FF, 12, -1, 8'h00);

        wait_clk(5);
        finish_run();
    end
endmodule